// File: doc/BRIEF.md
# Authenticated Cipher Operation Sequencer

This block is the control unit in front of an authenticated counter-mode cipher. It keeps the current key, takes one start command at a time and runs the operation to its end. Each start carries an encrypt/decrypt bit, a bypass bit, a 96-bit IV and two byte counts: one for associated data and one for payload. While the operation runs, the sequencer asks for one 128-bit input block per cycle. It sends associated-data blocks to the hash path only. It sends payload blocks through the cipher path and, unless bypass is set, also to the hash path. It then produces the end-of-operation handshake: finish, busy release and a one-cycle tag-valid pulse.

The cipher and hash arithmetic are not part of this block. A fixed-latency stub stands in for them. The stub XORs each payload block with a keystream stand-in. It also folds every hashed block into a 128-bit accumulator, and this accumulator gives the tag. Both stub results are defined exactly, so the steering can be observed at the ports.

The controller is a four-state machine:
- `ST_IDLE` moves to `ST_PREP` when a start is accepted.
- `ST_PREP` moves to `ST_READ` when the prologue count expires and there is at least one block. If there are no blocks, it moves to `ST_DRAIN` instead.
- `ST_READ` moves to `ST_DRAIN` after the last block is read.
- `ST_DRAIN` moves back to `ST_IDLE` after the pipeline latency, and finish is raised in its last cycle.

Top module: `gcm_op_sequencer`

## Requirements
- R1: The keystream stand-in is `key[255:128] ^ (key_wide ? key[127:0] : 0)`. With `key_wide`=0 the low 128 key bits have no effect; with `key_wide`=1 all 256 bits are used.
- R2: A key captured on `key_load` is used by every later operation until the next accepted `key_load`. A `key_load` that arrives while `busy` is high is ignored.
- R3: A `start` is ignored when `key_load` is high in the same cycle, and when `busy` is high.
- R4: Mode, bypass, IV and both byte counts are captured when a start is accepted. Later changes on those inputs do not affect the running operation or its tag.
- R5: `rd_strobe` first rises exactly 14 cycles after the cycle in which the start was accepted. It then stays high for one unbroken run of block reads.
- R6: The number of strobe cycles is ceil(aad_bytes/16) + ceil(data_bytes/16). Associated-data blocks come first, and either count may be zero.
- R7: `out_valid` rises only for payload blocks, 3 cycles after the strobe cycle that read the block. In cipher mode `data_out` = block ^ keystream ^ {IV, j}, where j is the 32-bit payload block number starting at 1.
- R8: `finish` is high for one cycle, in the last cycle of the operation: 16 + block count cycles after the accepted start. `busy` is low on the cycle after that.
- R9: Outside bypass, `tag_valid` is high for exactly one cycle, the cycle after `busy` clears. `tag_out` then equals the XOR of all associated-data blocks, all ciphertext blocks and the word {aad_bytes, data_bytes, IV}. Ciphertext is the output blocks when `decrypt`=0 and the input blocks when `decrypt`=1.
- R10: A start that arrives in the cycle right after `finish` is accepted, so operations run back to back.
- R11: With `bypass`=1, payload blocks leave unchanged on `data_out` and `tag_valid` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_load | input | 1 | Capture `key_in` and `key_wide` |
| key_wide | input | 1 | 0: 128-bit key in `key_in[255:128]`; 1: 256-bit key |
| key_in | input | 256 | Key value |
| start | input | 1 | Start command |
| decrypt | input | 1 | 0: encrypt, 1: decrypt |
| bypass | input | 1 | 1: pass payload through unchanged, no tag |
| iv_in | input | 96 | Initialisation vector |
| aad_bytes | input | 16 | Associated-data length in bytes |
| data_bytes | input | 16 | Payload length in bytes |
| busy | output | 1 | Operation in progress |
| finish | output | 1 | Last cycle of the operation |
| rd_strobe | output | 1 | `data_in` is consumed this cycle |
| data_in | input | 128 | Input block, associated data first, then payload |
| out_valid | output | 1 | `data_out` holds a payload result |
| data_out | output | 128 | Payload result |
| tag_valid | output | 1 | `tag_out` is valid |
| tag_out | output | 128 | Tag stand-in |

## Verification
The operations cover several count shapes:
- lengths aligned to 16 bytes and lengths that are not;
- empty associated data and empty payload;
- both counts zero, which checks the prologue-to-drain path with no reads;
- associated data only.

Encrypt and decrypt runs are compared: they differ only in whether the output side or the input side of the cipher is hashed, and only the tag shows which one was used. A 128-bit key whose low half is nonzero shows whether the key-size flag is honoured. Further runs check the rest of the control:
- start and key-load are raised during a busy operation;
- start and key-load arrive together;
- a second start is issued on the cycle right after finish;
- a set of operations uses randomised lengths and modes.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PREP  = 2'd1,
        ST_READ  = 2'd2,
        ST_DRAIN = 2'd3
    } seq_state_t;
endpackage

// File: rtl/key_store.sv
module key_store #(
    parameter int KEY_W = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               key_load,
    input  logic               key_wide,
    input  logic [KEY_W-1:0]   key_in,
    input  logic               busy,
    output logic [KEY_W/2-1:0] keystream
);
    localparam int HALF = KEY_W / 2;

    logic [KEY_W-1:0] key_q;
    logic             wide_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q  <= '0;
            wide_q <= 1'b0;
        end else if (key_load && !busy) begin
            key_q  <= key_in;
            wide_q <= key_wide;
        end
    end

    always_comb begin
        keystream = key_q[KEY_W-1:HALF] ^ (wide_q ? key_q[HALF-1:0] : '0);
    end

    assert_key_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_load && busy) |=> $stable(key_q) && $stable(wide_q));
endmodule

// File: rtl/op_fsm.sv
module op_fsm
    import seq_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int IV_W     = 96,
    parameter int RD_DELAY = 14,
    parameter int LAT      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             key_load,
    input  logic             decrypt,
    input  logic             bypass,
    input  logic [IV_W-1:0]  iv_in,
    input  logic [CNT_W-1:0] aad_bytes,
    input  logic [CNT_W-1:0] data_bytes,
    output logic             go,
    output logic             busy,
    output logic             rd,
    output logic             rd_aad,
    output logic             finish,
    output logic [31:0]      pay_idx,
    output logic             mode_q,
    output logic             byp_q,
    output logic [IV_W-1:0]  iv_q,
    output logic [CNT_W-1:0] aad_q,
    output logic [CNT_W-1:0] dat_q
);
    localparam int BLK_W    = CNT_W - 2;
    localparam int PREP_CYC = RD_DELAY - 1;
    localparam int PH_MAX   = (PREP_CYC > LAT) ? PREP_CYC : LAT;
    localparam int PH_W     = $clog2(PH_MAX + 1);
    localparam int SG_W     = $clog2(RD_DELAY + 2);

    seq_state_t       state_q, state_d;
    logic [PH_W-1:0]  ph_q;
    logic [BLK_W-1:0] blk_q;
    logic [BLK_W-1:0] naad, ndat, nblk;

    function automatic logic [BLK_W-1:0] blocks_of(input logic [CNT_W-1:0] b);
        logic [CNT_W:0] t;
        t = {1'b0, b} + (CNT_W+1)'(15);
        return BLK_W'(t >> 4);
    endfunction

    always_comb begin
        naad = blocks_of(aad_q);
        ndat = blocks_of(dat_q);
        nblk = naad + ndat;
    end

    assign go = start && !key_load && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go) state_d = ST_PREP;
            ST_PREP:  if (ph_q == PH_W'(PREP_CYC - 1))
                          state_d = (nblk != '0) ? ST_READ : ST_DRAIN;
            ST_READ:  if (blk_q == nblk - BLK_W'(1)) state_d = ST_DRAIN;
            ST_DRAIN: if (ph_q == PH_W'(LAT - 1)) state_d = ST_IDLE;
        endcase
    end

    // counters and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= '0;
            blk_q  <= '0;
            mode_q <= 1'b0;
            byp_q  <= 1'b0;
            iv_q   <= '0;
            aad_q  <= '0;
            dat_q  <= '0;
        end else begin
            if (state_d != state_q)                           ph_q <= '0;
            else if (state_q == ST_PREP || state_q == ST_DRAIN) ph_q <= ph_q + PH_W'(1);
            if (go)                     blk_q <= '0;
            else if (state_q == ST_READ) blk_q <= blk_q + BLK_W'(1);
            if (go) begin
                mode_q <= decrypt;
                byp_q  <= bypass;
                iv_q   <= iv_in;
                aad_q  <= aad_bytes;
                dat_q  <= data_bytes;
            end
        end
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        rd      = 1'b0;
        rd_aad  = 1'b0;
        finish  = 1'b0;
        pay_idx = 32'(blk_q - naad) + 32'd1;
        unique case (state_q)
            ST_IDLE:  ;
            ST_PREP:  busy = 1'b1;
            ST_READ: begin
                busy   = 1'b1;
                rd     = 1'b1;
                rd_aad = (blk_q < naad);
            end
            ST_DRAIN: begin
                busy   = 1'b1;
                finish = (ph_q == PH_W'(LAT - 1));
            end
        endcase
    end

    // checker state: cycles since accepted start, previous strobe
    logic [SG_W-1:0] since_go;
    logic            rd_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_go <= '0;
            rd_prev  <= 1'b0;
        end else begin
            rd_prev <= rd;
            if (go)                  since_go <= SG_W'(1);
            else if (since_go != '1) since_go <= since_go + SG_W'(1);
        end
    end

    assert_first_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !rd_prev) |-> since_go == SG_W'(RD_DELAY));
    assert_rd_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> busy);
    assert_finish_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> busy);
    assert_busy_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !busy);
    assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (busy || key_load)) |=> $stable(iv_q) && $stable(aad_q) && $stable(dat_q));
endmodule

// File: rtl/cipher_pipe.sv
module cipher_pipe #(
    parameter int DW  = 128,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          pass,
    input  logic [DW-1:0] blk,
    input  logic [DW-1:0] mask,
    output logic          out_valid,
    output logic [DW-1:0] data_out
);
    logic [LAT-1:0] v_q;
    logic [DW-1:0]  d_q [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q[0] <= 1'b0;
            d_q[0] <= '0;
        end else begin
            v_q[0] <= take;
            d_q[0] <= pass ? blk : (blk ^ mask);
        end
    end

    for (genvar i = 1; i < LAT; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q[i] <= 1'b0;
                d_q[i] <= '0;
            end else begin
                v_q[i] <= v_q[i-1];
                d_q[i] <= d_q[i-1];
            end
        end
    end

    assign out_valid = v_q[LAT-1];
    assign data_out  = d_q[LAT-1];
endmodule

// File: rtl/tag_fold.sv
module tag_fold #(
    parameter int DW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          rd,
    input  logic          rd_aad,
    input  logic [DW-1:0] data_in,
    input  logic          out_valid,
    input  logic [DW-1:0] data_out,
    input  logic          mode_q,
    input  logic          byp_q,
    input  logic          finish,
    input  logic [DW-1:0] len_word,
    output logic          tag_valid,
    output logic [DW-1:0] tag_out
);
    logic [DW-1:0] acc_q, in_term, out_term;
    logic          fin_d1;

    always_comb begin
        in_term  = (rd && (rd_aad || (mode_q && !byp_q))) ? data_in : '0;
        out_term = (out_valid && !mode_q && !byp_q) ? data_out : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            fin_d1    <= 1'b0;
            tag_valid <= 1'b0;
            tag_out   <= '0;
        end else begin
            acc_q     <= go ? '0 : (acc_q ^ in_term ^ out_term);
            fin_d1    <= finish;
            tag_valid <= fin_d1 && !byp_q;
            if (fin_d1) tag_out <= acc_q ^ len_word;
        end
    end

    assert_tag_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |=> !tag_valid);
    assert_no_tag_bypass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_d1 && byp_q) |=> !tag_valid);
endmodule

// File: rtl/gcm_op_sequencer.sv
module gcm_op_sequencer #(
    parameter int KEY_W    = 256,
    parameter int DW       = 128,
    parameter int IV_W     = 96,
    parameter int CNT_W    = 16,
    parameter int RD_DELAY = 14,
    parameter int LAT      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_load,
    input  logic             key_wide,
    input  logic [KEY_W-1:0] key_in,
    input  logic             start,
    input  logic             decrypt,
    input  logic             bypass,
    input  logic [IV_W-1:0]  iv_in,
    input  logic [CNT_W-1:0] aad_bytes,
    input  logic [CNT_W-1:0] data_bytes,
    output logic             busy,
    output logic             finish,
    output logic             rd_strobe,
    input  logic [DW-1:0]    data_in,
    output logic             out_valid,
    output logic [DW-1:0]    data_out,
    output logic             tag_valid,
    output logic [DW-1:0]    tag_out
);
    logic             go, rd_aad, mode_q, byp_q;
    logic [31:0]      pay_idx;
    logic [IV_W-1:0]  iv_q;
    logic [CNT_W-1:0] aad_q, dat_q;
    logic [DW-1:0]    keystream, blk_mask, len_word;

    key_store #(.KEY_W(KEY_W)) u_key (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_wide(key_wide),
        .key_in(key_in), .busy(busy), .keystream(keystream)
    );

    op_fsm #(.CNT_W(CNT_W), .IV_W(IV_W), .RD_DELAY(RD_DELAY), .LAT(LAT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .key_load(key_load),
        .decrypt(decrypt), .bypass(bypass), .iv_in(iv_in),
        .aad_bytes(aad_bytes), .data_bytes(data_bytes),
        .go(go), .busy(busy), .rd(rd_strobe), .rd_aad(rd_aad), .finish(finish),
        .pay_idx(pay_idx), .mode_q(mode_q), .byp_q(byp_q), .iv_q(iv_q),
        .aad_q(aad_q), .dat_q(dat_q)
    );

    assign blk_mask = keystream ^ DW'({iv_q, pay_idx});
    assign len_word = DW'({aad_q, dat_q, iv_q});

    cipher_pipe #(.DW(DW), .LAT(LAT)) u_pipe (
        .clk(clk), .rst_n(rst_n), .take(rd_strobe && !rd_aad), .pass(byp_q),
        .blk(data_in), .mask(blk_mask), .out_valid(out_valid), .data_out(data_out)
    );

    tag_fold #(.DW(DW)) u_tag (
        .clk(clk), .rst_n(rst_n), .go(go), .rd(rd_strobe), .rd_aad(rd_aad),
        .data_in(data_in), .out_valid(out_valid), .data_out(data_out),
        .mode_q(mode_q), .byp_q(byp_q), .finish(finish), .len_word(len_word),
        .tag_valid(tag_valid), .tag_out(tag_out)
    );

    assert_out_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
    assert_tag_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> !$past(busy));
endmodule

// File: tb/sim_gcm_op_sequencer.sv
`timescale 1ns/1ps
module sim_gcm_op_sequencer;
    logic         clk = 1'b0, rst_n = 1'b0;
    logic         key_load = 0, key_wide = 0, start = 0, decrypt = 0, bypass = 0;
    logic [255:0] key_in = '0;
    logic [95:0]  iv_in = '0;
    logic [15:0]  aad_bytes = '0, data_bytes = '0;
    logic [127:0] data_in = '0;
    logic         busy, finish, rd_strobe, out_valid, tag_valid;
    logic [127:0] data_out, tag_out;

    int n_chk = 0, n_bad = 0;
    logic [255:0] kexp = '0;
    logic         kwexp = 1'b0;
    bit           disturb = 0, chain = 0;
    logic [95:0]  nx_iv;
    logic [15:0]  nx_aad, nx_dat;
    logic         nx_dec, nx_byp;

    always #4 clk = ~clk;

    gcm_op_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_wide(key_wide),
        .key_in(key_in), .start(start), .decrypt(decrypt), .bypass(bypass),
        .iv_in(iv_in), .aad_bytes(aad_bytes), .data_bytes(data_bytes),
        .busy(busy), .finish(finish), .rd_strobe(rd_strobe), .data_in(data_in),
        .out_valid(out_valid), .data_out(data_out), .tag_valid(tag_valid), .tag_out(tag_out)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] pat(input int k);
        return {32'(k) * 32'h9E37_79B9, ~32'(k), 32'hA5A5_0000 + 32'(k), 32'(k) << 3};
    endfunction

    function automatic logic [127:0] mask(input int j, input logic [95:0] iv);
        logic [127:0] ks;
        ks = kexp[255:128] ^ (kwexp ? kexp[127:0] : 128'h0);
        return ks ^ {iv, 32'(j)};
    endfunction

    task automatic load_key(input logic [255:0] k, input logic w);
        key_in = k; key_wide = w; key_load = 1;
        @(negedge clk);
        key_load = 0;
        kexp = k; kwexp = w;
    endtask

    task automatic launch(input logic [15:0] a, input logic [15:0] d,
                          input logic dec, input logic byp, input logic [95:0] iv);
        aad_bytes = a; data_bytes = d; decrypt = dec; bypass = byp; iv_in = iv; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    // observes one operation; entered at the negedge of cycle 1 after the accepted start
    task automatic mon(input logic [15:0] a, input logic [15:0] d,
                       input logic dec, input logic byp, input logic [95:0] iv);
        int naad, n, last, rdn, outn, rd_err, ov_err, fin_err, bz_err, tv_err;
        int exp_c[$];
        logic [127:0] exp_d[$];
        logic [127:0] tagx, ed, ex;
        naad = (int'(a) + 15) / 16;
        n    = naad + (int'(d) + 15) / 16;
        last = 18 + n;
        rdn = 0; outn = 0; rd_err = 0; ov_err = 0; fin_err = 0; bz_err = 0; tv_err = 0;
        tagx = '0;
        for (int c = 1; c <= last; c++) begin
            if (c == 2) begin // R4: scramble the operands after capture
                iv_in = ~iv; aad_bytes = a ^ 16'h5A5A; data_bytes = d ^ 16'h0F0F;
                decrypt = ~dec; bypass = ~byp;
            end
            if (disturb && c == 5) start = 1;
            if (disturb && c == 6) begin
                start = 0; key_load = 1; key_in = ~kexp; key_wide = ~kwexp;
            end
            if (disturb && c == 7) key_load = 0;
            if (chain && c == last - 1) begin
                iv_in = nx_iv; aad_bytes = nx_aad; data_bytes = nx_dat;
                decrypt = nx_dec; bypass = nx_byp; start = 1;
            end
            if (chain && c == last) start = 0;
            if (rd_strobe !== (c >= 14 && c < 14 + n)) rd_err++;
            if (rd_strobe === 1'b1) begin
                data_in = pat(rdn);
                if (rdn < naad) tagx ^= pat(rdn);
                else begin
                    ed = byp ? pat(rdn) : (pat(rdn) ^ mask(rdn - naad + 1, iv));
                    exp_c.push_back(c + 3);
                    exp_d.push_back(ed);
                    if (!byp) tagx ^= dec ? pat(rdn) : ed;
                end
                rdn++;
            end
            if (exp_c.size() > 0 && exp_c[0] == c) begin
                if (out_valid !== 1'b1) ov_err++;
                ex = exp_d.pop_front();
                void'(exp_c.pop_front());
                chk(data_out === ex, byp ? "R11 payload" : "R7 R4 payload", data_out, ex);
                outn++;
            end else if (out_valid !== 1'b0) ov_err++;
            if (finish !== (c == 16 + n)) fin_err++;
            if (c <= 17 + n && busy !== (c <= 16 + n)) bz_err++;
            if (c >= 2 && tag_valid !== (!byp && c == last)) tv_err++;
            if (c == last && !byp) begin
                ex = tagx ^ {a, d, iv};
                chk(tag_out === ex, "R9 tag value", tag_out, ex);
            end
            if (c < last) @(negedge clk);
        end
        chk(rdn == n, "R6 strobe count", 128'(rdn), 128'(n));
        chk(rd_err == 0, "R5 strobe timing", 128'(rd_err), 0);
        chk(ov_err == 0 && outn == (int'(d) + 15) / 16, "R7 out_valid timing", 128'(ov_err), 0);
        chk(fin_err == 0, "R8 finish cycle", 128'(fin_err), 0);
        chk(bz_err == 0, "R8 busy release", 128'(bz_err), 0);
        chk(tv_err == 0, byp ? "R11 no tag" : "R9 tag pulse", 128'(tv_err), 0);
    endtask

    task automatic t_reset;
        chk(busy === 0 && finish === 0 && rd_strobe === 0, "R8 reset control", {busy, finish, rd_strobe}, 0);
        chk(out_valid === 0 && tag_valid === 0, "R9 reset valids", {out_valid, tag_valid}, 0);
    endtask

    task automatic t_encrypt_wide;
        load_key({128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687, 128'h1111_2222_3333_4444_5555_6666_7777_8888}, 1'b1);
        launch(16'd30, 16'd15, 1'b0, 1'b0, 96'hCAFE_0000_1111_2222_3333_4444);
        mon(16'd30, 16'd15, 1'b0, 1'b0, 96'hCAFE_0000_1111_2222_3333_4444);
    endtask

    task automatic t_decrypt_narrow; // R1: low half of a narrow key must not matter
        load_key({128'hDEAD_BEEF_0000_1234_5678_9ABC_DEF0_1357, 128'hFFFF_0000_FFFF_0000_1234_4321_AAAA_5555}, 1'b0);
        launch(16'd0, 16'd40, 1'b1, 1'b0, 96'h0BAD_F00D_7777_8888_9999_AAAA);
        mon(16'd0, 16'd40, 1'b1, 1'b0, 96'h0BAD_F00D_7777_8888_9999_AAAA);
    endtask

    task automatic t_bypass;
        launch(16'd16, 16'd33, 1'b0, 1'b1, 96'h1);
        mon(16'd16, 16'd33, 1'b0, 1'b1, 96'h1);
    endtask

    task automatic t_empty;
        launch(16'd0, 16'd0, 1'b0, 1'b0, 96'h55);
        mon(16'd0, 16'd0, 1'b0, 1'b0, 96'h55);
        launch(16'd5, 16'd0, 1'b1, 1'b0, 96'h66);
        mon(16'd5, 16'd0, 1'b1, 1'b0, 96'h66);
    endtask

    task automatic t_start_with_keyload; // R3, then R2 with the key loaded
        int seen;
        seen = 0;
        key_in = {128'h7, 128'h9}; key_wide = 1'b1; key_load = 1; start = 1;
        aad_bytes = 16'd16; data_bytes = 16'd16;
        @(negedge clk);
        key_load = 0; start = 0;
        kexp = {128'h7, 128'h9}; kwexp = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (busy !== 1'b0 || rd_strobe !== 1'b0) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R3 start with key_load", 128'(seen), 0);
        launch(16'd16, 16'd17, 1'b0, 1'b0, 96'hABC);
        mon(16'd16, 16'd17, 1'b0, 1'b0, 96'hABC);
    endtask

    task automatic t_disturb; // R2 and R3 while busy
        disturb = 1;
        launch(16'd20, 16'd48, 1'b0, 1'b0, 96'h4242);
        mon(16'd20, 16'd48, 1'b0, 1'b0, 96'h4242);
        disturb = 0;
        launch(16'd0, 16'd16, 1'b0, 1'b0, 96'h4343); // R2: old key still in use
        mon(16'd0, 16'd16, 1'b0, 1'b0, 96'h4343);
    endtask

    task automatic t_back_to_back;
        nx_iv = 96'h9999; nx_aad = 16'd3; nx_dat = 16'd50; nx_dec = 1'b1; nx_byp = 1'b0;
        chain = 1;
        launch(16'd17, 16'd8, 1'b0, 1'b0, 96'h8888);
        mon(16'd17, 16'd8, 1'b0, 1'b0, 96'h8888);
        chain = 0;
        chk(busy === 1'b1, "R10 start after finish", 128'(busy), 1);
        mon(16'd3, 16'd50, 1'b1, 1'b0, 96'h9999);
    endtask

    task automatic t_random;
        for (int i = 0; i < 8; i++) begin
            logic [15:0] a, d;
            logic dec, byp;
            logic [95:0] iv;
            a = 16'($urandom_range(0, 70)); d = 16'($urandom_range(0, 90));
            dec = 1'($urandom_range(0, 1)); byp = ($urandom_range(0, 3) == 0);
            iv = {$urandom, $urandom, $urandom};
            launch(a, d, dec, byp, iv);
            mon(a, d, dec, byp, iv);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_encrypt_wide();
        t_decrypt_narrow();
        t_bypass();
        t_empty();
        t_start_with_keyload();
        t_disturb();
        t_back_to_back();
        t_random();
        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule